// File: doc/BRIEF.md
# Delay-Line Lock Controller

This block is the digital control loop of a calibrated delay line. A reference pulse travels down a chain of delay stages, and the tap outputs of that chain arrive at the block as an asynchronous vector. At every rising clock edge the block captures the taps and passes them through a two-flop synchronizer. It then finds where the reference's falling edge sits along the line. If the edge has not yet reached the last stage, the delay code is raised. If the edge has already run off the end, the code is lowered. If the edge sits exactly at the tail, the line counts as matched.

The delay code drives the line being calibrated. It can also drive a second, matched line, so that an unrelated signal sees the same delay as the reference. The code saturates at both ends. A single-cycle strobe marks each step up or down. A lock flag with hysteresis reports a stable match.

Within a snapshot, a falling-edge marker at index i means tap i is low and tap i+1 is high. Tap 0 is the input end of the line.

Top module: `dline_lock_ctrl`

## Requirements
- R1: During and after reset the delay code equals the mid-scale value 2^(CODE_W-1) (32 by default), both strobes are low and the lock flag is low.
- R2: A tap pattern present at one rising edge k changes the delay code and strobes at edge k+2, and not earlier (capture flop plus one synchronizer flop, then the code register).
- R3: A snapshot with exactly one falling-edge marker, at an index below N_TAPS-2, raises the code by one and pulses the up strobe for one cycle.
- R4: A snapshot with no marker and tap N_TAPS-1 low (edge gone past the tail) lowers the code by one and pulses the down strobe for one cycle.
- R5: A snapshot whose only marker is at index N_TAPS-2 (tap N_TAPS-2 low, tap N_TAPS-1 high) is a tail hit and leaves the code unchanged.
- R6: A snapshot with no marker and tap N_TAPS-1 high (no edge in the line) changes neither the code nor the hit or miss history.
- R7: A snapshot with two or more markers is a bubble. It is discarded with no code change and no effect on the hit or miss history.
- R8: The code holds at 2^CODE_W-1 on a further raise request and at 0 on a further lower request, and no strobe is issued then.
- R9: The lock flag rises on the third consecutive tail hit. Idle and bubble snapshots do not break the run.
- R10: Once locked, the flag falls on the second consecutive raise or lower decision. A tail hit in between restarts the miss run.
- R11: The up and down strobes are never high together, and each strobe cycle matches exactly one code step.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Sampling clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| tap_in | input | N_TAPS | Asynchronous delay-chain tap outputs, bit 0 nearest the line input |
| delay_code | output | CODE_W | Delay control code for the calibrated line and its matched copy |
| inc_pulse | output | 1 | One-cycle strobe: code was raised |
| dec_pulse | output | 1 | One-cycle strobe: code was lowered |
| locked | output | 1 | Tail of the line matched with hysteresis |

## Verification
A misclassified snapshot shows at the ports two edges after its capture. It appears as a wrong code step or as a strobe that is present or missing. A miscounted synchronizer depth moves that step a cycle early or late. A faulty hit or miss counter only appears at the lock flag, and only after a run of three hits or two misses. For that reason the bench interleaves idle and bubble snapshots inside those runs, and it also drives the code against both saturation limits.

// File: rtl/dll_lock_pkg.sv
package dll_lock_pkg;

  typedef enum logic [2:0] {
    VD_IDLE   = 3'd0,
    VD_HIT    = 3'd1,
    VD_EARLY  = 3'd2,
    VD_LATE   = 3'd3,
    VD_BUBBLE = 3'd4
  } verdict_e;

  // True when a decision asks the loop to move the code.
  function automatic logic is_miss(input verdict_e v);
    return (v == VD_EARLY) || (v == VD_LATE);
  endfunction

endpackage

// File: rtl/dll_tap_sync.sv
module dll_tap_sync #(
  parameter int W      = 16,
  parameter int STAGES = 2
) (
  input  logic         clk,
  input  logic         rst_n,
  input  logic [W-1:0] din,
  output logic [W-1:0] dout
);
  // The first stage is the capture flop; the rest settle metastability.
  // Reset value is all ones, which classifies as an idle snapshot.
  for (genvar b = 0; b < W; b++) begin : g_bit
    logic [STAGES-1:0] sh;
    always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) sh <= '1;
      else        sh <= {sh[STAGES-2:0], din[b]};
    end
    assign dout[b] = sh[STAGES-1];
  end
endmodule

// File: rtl/dll_edge_classify.sv
module dll_edge_classify
  import dll_lock_pkg::*;
#(
  parameter int N_TAPS = 16
) (
  input  logic [N_TAPS-1:0] snap,
  output verdict_e          verdict
);
  localparam int TAIL = N_TAPS - 2;
  localparam int CW   = $clog2(N_TAPS) + 1;

  logic [N_TAPS-2:0] fall_mark;
  logic [CW-1:0]     n_marks;

  // Marker at i: the stage nearer the input has already fallen while
  // the next one still holds the pulse.
  for (genvar i = 0; i < N_TAPS - 1; i++) begin : g_mark
    assign fall_mark[i] = ~snap[i] & snap[i+1];
  end

  always_comb begin
    n_marks = '0;
    for (int i = 0; i < N_TAPS - 1; i++)
      n_marks = n_marks + CW'(fall_mark[i]);
  end

  always_comb begin
    if (n_marks > CW'(1))       verdict = VD_BUBBLE;
    else if (n_marks == CW'(1)) verdict = fall_mark[TAIL] ? VD_HIT : VD_EARLY;
    else                        verdict = snap[N_TAPS-1] ? VD_IDLE : VD_LATE;
  end
endmodule

// File: rtl/dll_code_step.sv
module dll_code_step
  import dll_lock_pkg::*;
#(
  parameter int CODE_W     = 6,
  parameter int RESET_CODE = 32
) (
  input  logic              clk,
  input  logic              rst_n,
  input  verdict_e          verdict,
  output logic [CODE_W-1:0] code,
  output logic              inc_pulse,
  output logic              dec_pulse
);
  localparam logic [CODE_W-1:0] CODE_MAX = '1;
  localparam logic [CODE_W-1:0] CODE_RST = CODE_W'(RESET_CODE);

  logic want_inc, want_dec;

  assign want_inc = (verdict == VD_EARLY) && (code != CODE_MAX);
  assign want_dec = (verdict == VD_LATE)  && (code != '0);

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      code      <= CODE_RST;
      inc_pulse <= 1'b0;
      dec_pulse <= 1'b0;
    end else begin
      inc_pulse <= want_inc;
      dec_pulse <= want_dec;
      if (want_inc)      code <= code + 1'b1;
      else if (want_dec) code <= code - 1'b1;
    end
  end
endmodule

// File: rtl/dll_lock_track.sv
module dll_lock_track
  import dll_lock_pkg::*;
#(
  parameter int LOCK_HITS     = 3,
  parameter int UNLOCK_MISSES = 2
) (
  input  logic     clk,
  input  logic     rst_n,
  input  verdict_e verdict,
  output logic     hit_evt,
  output logic     miss_evt,
  output logic     locked
);
  localparam int HW = $clog2(LOCK_HITS + 1);
  localparam int MW = $clog2(UNLOCK_MISSES + 1);

  logic [HW-1:0] hit_cnt, hit_nxt;
  logic [MW-1:0] miss_cnt, miss_nxt;

  assign hit_evt  = (verdict == VD_HIT);
  assign miss_evt = is_miss(verdict);
  assign hit_nxt  = (hit_cnt == HW'(LOCK_HITS)) ? hit_cnt : hit_cnt + 1'b1;
  assign miss_nxt = (miss_cnt == MW'(UNLOCK_MISSES)) ? miss_cnt : miss_cnt + 1'b1;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      hit_cnt  <= '0;
      miss_cnt <= '0;
      locked   <= 1'b0;
    end else if (hit_evt) begin
      hit_cnt  <= hit_nxt;
      miss_cnt <= '0;
      if (hit_nxt == HW'(LOCK_HITS)) locked <= 1'b1;
    end else if (miss_evt) begin
      miss_cnt <= miss_nxt;
      hit_cnt  <= '0;
      if (miss_nxt == MW'(UNLOCK_MISSES)) locked <= 1'b0;
    end
  end
endmodule

// File: rtl/dline_lock_ctrl.sv
module dline_lock_ctrl
  import dll_lock_pkg::*;
#(
  parameter int N_TAPS        = 16,
  parameter int CODE_W        = 6,
  parameter int SYNC_STAGES   = 2,
  parameter int LOCK_HITS     = 3,
  parameter int UNLOCK_MISSES = 2
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic [N_TAPS-1:0] tap_in,
  output logic [CODE_W-1:0] delay_code,
  output logic              inc_pulse,
  output logic              dec_pulse,
  output logic              locked
);
  localparam int MID_CODE = 1 << (CODE_W - 1);

  logic [N_TAPS-1:0] snap_sync;
  verdict_e          verdict;
  logic              hit_evt;
  logic              miss_evt;

  dll_tap_sync #(.W(N_TAPS), .STAGES(SYNC_STAGES)) u_sync (
    .clk(clk), .rst_n(rst_n), .din(tap_in), .dout(snap_sync)
  );

  dll_edge_classify #(.N_TAPS(N_TAPS)) u_cls (
    .snap(snap_sync), .verdict(verdict)
  );

  dll_code_step #(.CODE_W(CODE_W), .RESET_CODE(MID_CODE)) u_step (
    .clk(clk), .rst_n(rst_n), .verdict(verdict),
    .code(delay_code), .inc_pulse(inc_pulse), .dec_pulse(dec_pulse)
  );

  dll_lock_track #(.LOCK_HITS(LOCK_HITS), .UNLOCK_MISSES(UNLOCK_MISSES)) u_lock (
    .clk(clk), .rst_n(rst_n), .verdict(verdict),
    .hit_evt(hit_evt), .miss_evt(miss_evt), .locked(locked)
  );
endmodule

// File: rtl/dll_lock_chk.sv
module dll_lock_chk
  import dll_lock_pkg::*;
#(
  parameter int CODE_W = 6
) (
  input logic              clk,
  input logic              rst_n,
  input verdict_e          verdict,
  input logic [CODE_W-1:0] code,
  input logic              inc_pulse,
  input logic              dec_pulse,
  input logic              locked,
  input logic              hit_evt,
  input logic              miss_evt
);
  localparam logic [CODE_W-1:0] CMAX = '1;

  p_one_strobe_r11: assert property (@(posedge clk) disable iff (!rst_n)
    !(inc_pulse && dec_pulse));

  p_inc_step_r11: assert property (@(posedge clk) disable iff (!rst_n)
    inc_pulse |-> code == CODE_W'($past(code) + 1'b1));

  p_dec_step_r11: assert property (@(posedge clk) disable iff (!rst_n)
    dec_pulse |-> code == CODE_W'($past(code) - 1'b1));

  p_early_raises_r3: assert property (@(posedge clk) disable iff (!rst_n)
    (verdict == VD_EARLY && code != CMAX) |=> inc_pulse);

  p_late_lowers_r4: assert property (@(posedge clk) disable iff (!rst_n)
    (verdict == VD_LATE && code != '0) |=> dec_pulse);

  p_hit_holds_r5: assert property (@(posedge clk) disable iff (!rst_n)
    (verdict == VD_HIT) |=> $stable(code) && !inc_pulse && !dec_pulse);

  p_bubble_ignored_r7: assert property (@(posedge clk) disable iff (!rst_n)
    (verdict == VD_BUBBLE) |=> $stable(code) && $stable(locked));

  p_top_holds_r8: assert property (@(posedge clk) disable iff (!rst_n)
    (code == CMAX && verdict == VD_EARLY) |=> code == CMAX && !inc_pulse);

  p_bottom_holds_r8: assert property (@(posedge clk) disable iff (!rst_n)
    (code == '0 && verdict == VD_LATE) |=> code == '0 && !dec_pulse);

  p_lock_on_hit_r9: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(locked) |-> $past(hit_evt));

  p_unlock_on_miss_r10: assert property (@(posedge clk) disable iff (!rst_n)
    $fell(locked) |-> $past(miss_evt));
endmodule

bind dline_lock_ctrl dll_lock_chk #(.CODE_W(CODE_W)) u_chk (
  .clk(clk), .rst_n(rst_n), .verdict(verdict), .code(delay_code),
  .inc_pulse(inc_pulse), .dec_pulse(dec_pulse), .locked(locked),
  .hit_evt(hit_evt), .miss_evt(miss_evt)
);

// File: tb/dline_lock_ctrl_test.sv
module dline_lock_ctrl_test;
  localparam int CLK_PERIOD = 10;
  localparam int NT = 16;
  localparam int CMAXV = 63;
  localparam int NV = 17;
  localparam logic [NT-1:0] PAT_IDLE = 16'hFFFF;
  localparam logic [NT-1:0] PAT_EARLY = 16'hFFC0;
  localparam logic [NT-1:0] PAT_LATE = 16'h0000;
  localparam logic [NT-1:0] VEC [NV] = '{
    16'hFFC0, 16'h0000, 16'hFFFF, 16'hF0F0, 16'h8080, 16'h00FF,
    16'h7FFF, 16'h8001, 16'h8000, 16'hFFFF, 16'hF0F0, 16'h8000,
    16'hFFFE, 16'h8000, 16'h0001, 16'hCCCC, 16'hE000
  };

  logic clk = 1'b0;
  logic rst_n = 1'b0;
  logic [NT-1:0] tap_in = PAT_IDLE;
  logic [5:0] delay_code;
  logic inc_pulse, dec_pulse, locked;

  int total = 0, bad = 0;
  int m_code = 32, m_hits = 0, m_miss = 0, m_lock = 0;
  int exp_inc = 0, exp_dec = 0, seen_inc = 0, seen_dec = 0, seen_both = 0;
  string kind_tag [5] = '{"R6", "R5", "R3", "R4", "R7"};

  dline_lock_ctrl uut (
    .clk(clk), .rst_n(rst_n), .tap_in(tap_in), .delay_code(delay_code),
    .inc_pulse(inc_pulse), .dec_pulse(dec_pulse), .locked(locked)
  );

  always #(CLK_PERIOD/2) clk = ~clk;

  always @(negedge clk) begin
    if (inc_pulse) seen_inc++;
    if (dec_pulse) seen_dec++;
    if (inc_pulse && dec_pulse) seen_both++;
  end

  task automatic chk(string req, int act, int exp);
    total++;
    if (act != exp) begin
      bad++;
      $display("FAIL %s actual=%0d expected=%0d", req, act, exp);
    end
  endtask

  // 0 idle, 1 tail hit, 2 early, 3 late, 4 bubble
  function automatic int kind_of(logic [NT-1:0] p);
    int n = 0, pos = 0;
    for (int i = 0; i < NT - 1; i++)
      if (!p[i] && p[i+1]) begin n++; pos = i; end
    if (n > 1) return 4;
    if (n == 1) return (pos == NT - 2) ? 1 : 2;
    return p[NT-1] ? 0 : 3;
  endfunction

  task automatic model_step(int k);
    if (k == 1) begin
      m_miss = 0;
      if (m_hits < 3) m_hits++;
      if (m_hits == 3) m_lock = 1;
    end else if (k == 2 || k == 3) begin
      m_hits = 0;
      if (m_miss < 2) m_miss++;
      if (m_miss == 2) m_lock = 0;
      if (k == 2 && m_code < CMAXV) begin m_code++; exp_inc++; end
      if (k == 3 && m_code > 0) begin m_code--; exp_dec++; end
    end
  endtask

  task automatic send(logic [NT-1:0] p);
    @(negedge clk) tap_in = p;
    @(negedge clk) tap_in = PAT_IDLE;
    repeat (3) @(negedge clk);
    model_step(kind_of(p));
  endtask

  task automatic check_all(string tag);
    chk(tag, delay_code, m_code);
    chk("R9/R10 lock", locked, m_lock);
    chk("R11 up strobes", seen_inc, exp_inc);
    chk("R11 down strobes", seen_dec, exp_dec);
  endtask

  task automatic do_reset();
    rst_n = 1'b0;
    tap_in = PAT_IDLE;
    repeat (3) @(negedge clk);
    chk("R1 code in reset", delay_code, 32);
    rst_n = 1'b1;
    m_code = 32; m_hits = 0; m_miss = 0; m_lock = 0;
    @(negedge clk);
  endtask

  function automatic logic [NT-1:0] chain_pat(int code);
    int m = code - 24;
    if (m < 0) return PAT_IDLE;
    if (m > NT - 2) return PAT_LATE;
    return PAT_IDLE << (m + 1);
  endfunction

  initial begin
    #(CLK_PERIOD * 100000);
    bad++; total++;
    $display("FAIL watchdog expired actual=running expected=done");
    $display("test done: total=%0d bad=%0d", total, bad);
    $finish;
  end

  initial begin
    do_reset();
    chk("R1 code", delay_code, 32);
    chk("R1 lock", locked, 0);
    chk("R1 up strobe", inc_pulse, 0);
    chk("R1 down strobe", dec_pulse, 0);

    // R2: latency of the capture/synchronizer pipeline
    @(negedge clk) tap_in = PAT_EARLY;
    @(negedge clk) tap_in = PAT_IDLE;     // edge k passed
    @(negedge clk);                       // edge k+1 passed
    chk("R2 no change at k+1", delay_code, 32);
    @(negedge clk);                       // edge k+2 passed
    chk("R2 change at k+2", delay_code, 33);
    @(negedge clk);
    model_step(2);
    check_all("R2");

    // table walk: classification, lock run and unlock run
    for (int i = 0; i < NV; i++) begin
      send(VEC[i]);
      check_all(kind_tag[kind_of(VEC[i])]);
    end

    // R8: saturation at the top
    for (int i = 0; i < 35; i++) send(PAT_EARLY);
    chk("R8 top value", delay_code, CMAXV);
    check_all("R8 top");
    send(PAT_EARLY);
    check_all("R8 top hold");
    // R8: saturation at the bottom
    for (int i = 0; i < 70; i++) send(PAT_LATE);
    chk("R8 bottom value", delay_code, 0);
    check_all("R8 bottom");
    chk("R11 strobes never together", seen_both, 0);

    // closed loop against a behavioural chain: settles at code 38
    do_reset();
    for (int i = 0; i < 12; i++) send(chain_pat(int'(delay_code)));
    chk("R3 closed-loop code", delay_code, 38);
    chk("R9 closed-loop lock", locked, 1);
    check_all("R5 closed loop");

    $display("test done: total=%0d bad=%0d", total, bad);
    $finish;
  end
endmodule